// File: doc/BRIEF.md
# PCIe PHY bring-up sequencer

This block performs the timed power-up of a PCIe root-port PHY and its controller core after a single start request. It first places the PHY in a held state by asserting test power-down, turning on the training-enable control and gating the reference clock. If a board-level endpoint reset line is fitted, the block holds it low for a programmable time and then releases it. It then clears training-enable, raises power-on, removes test power-down and turns on the reference clock, each one a cycle later than the one before.

Next it requests four clocks in a fixed order: 100 MHz reference, 125 MHz reference, display-bridge gate, then bus clock. Each clock is a request/acknowledge pair. A clock that does not acknowledge within a timeout ends the sequence: every clock already requested is dropped again, last first, and the block reports failure. When all four clocks are running, the block waits a settle time, pulses a core-setup request for one cycle, turns training-enable back on and reports ready. Fixed PHY tuning values are driven on static output fields at all times. Every delay is counted in microsecond ticks derived from the system clock by a parameterised divider.

Top module: `pcie_phy_bringup`

## Requirements
- R1: While reset is asserted, and afterwards until the start request, test_pd_o, refclk_en_o, train_en_o, ep_rst_no, pwr_on_o, every bit of clk_en_o, core_setup_o, ready_o and fail_o are all 0.
- R2: A start_i pulse seen in idle makes test_pd_o=1, train_en_o=1, refclk_en_o=0 and ep_rst_no=0 on the next clock edge.
- R3: With rst_fitted_i=1, ep_rst_no rises RST_HOLD_US*TICK_DIV cycles after test_pd_o rises, within +3 cycles. With rst_fitted_i=0 it never rises during the run.
- R4: After the reset phase, train_en_o falls, then pwr_on_o rises, then test_pd_o falls, then refclk_en_o rises, each in a strictly later cycle than the previous one. refclk_en_o is never 1 while test_pd_o is 1.
- R5: The static fields always hold dev_type_o=4 (root port), los_lvl_o=9, deemph_g1_o=0, deemph_g2_3p5_o=0, deemph_g2_6_o=20, swing_full_o=127 and swing_low_o=127.
- R6: The clocks are requested on clk_en_o bit 0 (100 MHz reference), bit 1 (125 MHz reference), bit 2 (display-bridge gate) and bit 3 (bus clock), in that order. Bit 0 rises only after refclk_en_o, and bit i rises only after clk_ack_i bit i-1 has risen. The set bits of clk_en_o are always a contiguous run starting at bit 0.
- R7: If clk_ack_i bit k stays low, the request on bit k is withdrawn CLK_TMO_US*TICK_DIV cycles after it was raised, within +3 cycles. No clock above k is ever requested.
- R8: After a timeout on bit k, the enable bits k, k-1, ..., 0 fall one per cycle in that order. fail_o rises with the last one. Whenever fail_o is 1, clk_en_o is 0.
- R9: core_setup_o rises SETTLE_US*TICK_DIV cycles after the acknowledge of the last clock, within +4 cycles.
- R10: core_setup_o is high for exactly one cycle per successful run. train_en_o rises again after it, and ready_o is then 1 with all clocks, refclk_en_o and train_en_o high. A failed run never raises core_setup_o.
- R11: start_i has no effect outside idle; in the ready or fail state a start pulse changes no output.
- R12: ready_o and fail_o are never 1 together, and each stays 1 until reset once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the bring-up sequence (honoured in idle only) |
| rst_fitted_i | input | 1 | Board endpoint reset line is present |
| clk_ack_i | input | NUM_CLK | Per-clock running acknowledge |
| test_pd_o | output | 1 | PHY test power-down |
| refclk_en_o | output | 1 | PHY reference clock enable |
| train_en_o | output | 1 | Link-training enable to the core |
| ep_rst_no | output | 1 | Endpoint reset, active low |
| pwr_on_o | output | 1 | Slot power-on |
| clk_en_o | output | NUM_CLK | Per-clock enable request |
| core_setup_o | output | 1 | One-cycle core setup request |
| ready_o | output | 1 | Sequence finished successfully |
| fail_o | output | 1 | Sequence aborted on a clock timeout |
| dev_type_o | output | 4 | Device type field (root port) |
| los_lvl_o | output | 6 | Loss-of-signal detect level |
| deemph_g1_o | output | 6 | Gen1 de-emphasis |
| deemph_g2_3p5_o | output | 6 | Gen2 3.5 dB de-emphasis |
| deemph_g2_6_o | output | 6 | Gen2 6 dB de-emphasis |
| swing_full_o | output | 7 | Full transmit swing |
| swing_low_o | output | 7 | Low transmit swing |

## Verification
The bench runs every failing clock position and the all-good case, each with the endpoint reset present and absent, with the acknowledge delays varied between runs, plus one run where every acknowledge arrives just before the timeout. A design that unwound forward instead of in reverse, skipped the failed clock itself, or let a later clock start after a timeout shows wrong per-bit fall stamps or a stray rise. A timer that mis-loads or uses the wrong length shows up in the measured reset-hold, timeout and settle windows. A sequencer that re-arms on a late start pulse would change ready, fail or the clock enables after the pulse.

// File: rtl/pcie_bringup_pkg.sv
`timescale 1ns/1ps
package pcie_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_PHY_CFG,
    ST_PWR_ON,
    ST_PD_CLR,
    ST_REF_ON,
    ST_CLK_REQ,
    ST_CLK_WAIT,
    ST_UNWIND,
    ST_SETTLE,
    ST_SETUP,
    ST_READY,
    ST_FAIL
  } seq_state_e;

  localparam logic [3:0] DEV_TYPE_ROOT = 4'd4;
  localparam logic [5:0] LOS_LEVEL     = 6'd9;
  localparam logic [5:0] DEEMPH_G1     = 6'd0;
  localparam logic [5:0] DEEMPH_G2_3P5 = 6'd0;
  localparam logic [5:0] DEEMPH_G2_6   = 6'd20;
  localparam logic [6:0] SWING_FULL    = 7'd127;
  localparam logic [6:0] SWING_LOW     = 7'd127;

endpackage

// File: rtl/pcie_bringup_timer.sv
`timescale 1ns/1ps
// Microsecond down-counter; prescaler restarts on every load.
module pcie_bringup_timer #(
  parameter int TICK_DIV = 200,
  parameter int LEN_W    = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      pre_q  <= '0;
      cnt_q  <= len_i;
      busy_q <= (len_i != '0);
    end else if (busy_q) begin
      if (pre_q == PRE_W'(TICK_DIV - 1)) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == LEN_W'(1)) busy_q <= 1'b0;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/pcie_bringup_clkctl.sv
`timescale 1ns/1ps
// Per-clock enable flops with indexed set/clear and ack select.
module pcie_bringup_clkctl #(
  parameter int NUM_CLK = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_CLK-1:0] ack_i,
  output logic [NUM_CLK-1:0] en_o,
  output logic               ack_sel_o
);

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_en
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   en_q <= 1'b0;
      else if (set_i && idx_i == IDX_W'(g))          en_q <= 1'b1;
      else if (clr_i && idx_i == IDX_W'(g))          en_q <= 1'b0;
    end
    assign en_o[g] = en_q;
  end

  assign ack_sel_o = ack_i[idx_i];

endmodule

// File: rtl/pcie_phy_bringup.sv
`timescale 1ns/1ps
module pcie_phy_bringup
  import pcie_bringup_pkg::*;
#(
  parameter int NUM_CLK     = 4,
  parameter int TICK_DIV    = 200,
  parameter int RST_HOLD_US = 100000,
  parameter int CLK_TMO_US  = 50,
  parameter int SETTLE_US   = 300
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               rst_fitted_i,
  input  logic [NUM_CLK-1:0] clk_ack_i,
  output logic               test_pd_o,
  output logic               refclk_en_o,
  output logic               train_en_o,
  output logic               ep_rst_no,
  output logic               pwr_on_o,
  output logic [NUM_CLK-1:0] clk_en_o,
  output logic               core_setup_o,
  output logic               ready_o,
  output logic               fail_o,
  output logic [3:0]         dev_type_o,
  output logic [5:0]         los_lvl_o,
  output logic [5:0]         deemph_g1_o,
  output logic [5:0]         deemph_g2_3p5_o,
  output logic [5:0]         deemph_g2_6_o,
  output logic [6:0]         swing_full_o,
  output logic [6:0]         swing_low_o
);

  localparam int MAX_A  = (RST_HOLD_US > CLK_TMO_US) ? RST_HOLD_US : CLK_TMO_US;
  localparam int MAX_US = (MAX_A > SETTLE_US) ? MAX_A : SETTLE_US;
  localparam int LEN_W  = $clog2(MAX_US + 1);
  localparam int IDX_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pd_q, pd_d, ref_q, ref_d, train_q, train_d;
  logic             eprst_q, eprst_d, pwr_q, pwr_d;
  logic             tmr_start, tmr_busy;
  logic [LEN_W-1:0] tmr_len;
  logic             clk_set, clk_clr, ack_sel;

  pcie_bringup_timer #(.TICK_DIV(TICK_DIV), .LEN_W(LEN_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .len_i   (tmr_len),
    .busy_o  (tmr_busy)
  );

  pcie_bringup_clkctl #(.NUM_CLK(NUM_CLK), .IDX_W(IDX_W)) u_clkctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (clk_set),
    .clr_i     (clk_clr),
    .idx_i     (idx_q),
    .ack_i     (clk_ack_i),
    .en_o      (clk_en_o),
    .ack_sel_o (ack_sel)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    pd_d      = pd_q;
    ref_d     = ref_q;
    train_d   = train_q;
    eprst_d   = eprst_q;
    pwr_d     = pwr_q;
    tmr_start = 1'b0;
    tmr_len   = '0;
    clk_set   = 1'b0;
    clk_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        pd_d    = 1'b1;
        train_d = 1'b1;
        ref_d   = 1'b0;
        eprst_d = 1'b0;
        if (rst_fitted_i) begin
          tmr_start = 1'b1;
          tmr_len   = LEN_W'(RST_HOLD_US);
          state_d   = ST_RST_HOLD;
        end else begin
          state_d = ST_PHY_CFG;
        end
      end
      ST_RST_HOLD: if (!tmr_busy) begin
        eprst_d = 1'b1;
        state_d = ST_PHY_CFG;
      end
      ST_PHY_CFG: begin
        train_d = 1'b0;
        state_d = ST_PWR_ON;
      end
      ST_PWR_ON: begin
        pwr_d   = 1'b1;
        state_d = ST_PD_CLR;
      end
      ST_PD_CLR: begin
        pd_d    = 1'b0;
        state_d = ST_REF_ON;
      end
      ST_REF_ON: begin
        ref_d   = 1'b1;
        idx_d   = '0;
        state_d = ST_CLK_REQ;
      end
      ST_CLK_REQ: begin
        clk_set   = 1'b1;
        tmr_start = 1'b1;
        tmr_len   = LEN_W'(CLK_TMO_US);
        state_d   = ST_CLK_WAIT;
      end
      ST_CLK_WAIT: begin
        if (ack_sel) begin
          if (idx_q == IDX_W'(NUM_CLK - 1)) begin
            tmr_start = 1'b1;
            tmr_len   = LEN_W'(SETTLE_US);
            state_d   = ST_SETTLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_CLK_REQ;
          end
        end else if (!tmr_busy) begin
          state_d = ST_UNWIND;
        end
      end
      ST_UNWIND: begin
        clk_clr = 1'b1;
        if (idx_q == '0) state_d = ST_FAIL;
        else             idx_d   = idx_q - 1'b1;
      end
      ST_SETTLE: if (!tmr_busy) state_d = ST_SETUP;
      ST_SETUP: begin
        train_d = 1'b1;
        state_d = ST_READY;
      end
      ST_READY: ;
      ST_FAIL:  ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pd_q    <= 1'b0;
      ref_q   <= 1'b0;
      train_q <= 1'b0;
      eprst_q <= 1'b0;
      pwr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pd_q    <= pd_d;
      ref_q   <= ref_d;
      train_q <= train_d;
      eprst_q <= eprst_d;
      pwr_q   <= pwr_d;
    end
  end

  assign test_pd_o    = pd_q;
  assign refclk_en_o  = ref_q;
  assign train_en_o   = train_q;
  assign ep_rst_no    = eprst_q;
  assign pwr_on_o     = pwr_q;
  assign core_setup_o = (state_q == ST_SETUP);
  assign ready_o      = (state_q == ST_READY);
  assign fail_o       = (state_q == ST_FAIL);

  assign dev_type_o      = DEV_TYPE_ROOT;
  assign los_lvl_o       = LOS_LEVEL;
  assign deemph_g1_o     = DEEMPH_G1;
  assign deemph_g2_3p5_o = DEEMPH_G2_3P5;
  assign deemph_g2_6_o   = DEEMPH_G2_6;
  assign swing_full_o    = SWING_FULL;
  assign swing_low_o     = SWING_LOW;

endmodule

// File: rtl/pcie_phy_bringup_chk.sv
`timescale 1ns/1ps
module pcie_phy_bringup_chk #(
  parameter int NUM_CLK = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               test_pd_o,
  input logic               refclk_en_o,
  input logic               train_en_o,
  input logic               pwr_on_o,
  input logic [NUM_CLK-1:0] clk_en_o,
  input logic               core_setup_o,
  input logic               ready_o,
  input logic               fail_o
);

  AST_READY_FAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && fail_o)); // R12

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R12

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o); // R12

  AST_CLK_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clk_en_o + NUM_CLK'(1)) & clk_en_o) == '0); // R6

  AST_REF_NOT_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refclk_en_o |-> !test_pd_o); // R4

  AST_PD_CLR_AFTER_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(test_pd_o) |-> pwr_on_o); // R4

  AST_FAIL_CLKS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (clk_en_o == '0)); // R8

  AST_SETUP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_setup_o |=> !core_setup_o && train_en_o && ready_o); // R10

  AST_READY_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (&clk_en_o) && refclk_en_o && train_en_o); // R10

endmodule

bind pcie_phy_bringup pcie_phy_bringup_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .test_pd_o    (test_pd_o),
  .refclk_en_o  (refclk_en_o),
  .train_en_o   (train_en_o),
  .pwr_on_o     (pwr_on_o),
  .clk_en_o     (clk_en_o),
  .core_setup_o (core_setup_o),
  .ready_o      (ready_o),
  .fail_o       (fail_o)
);

// File: tb/pcie_phy_bringup_tb_top.sv
`timescale 1ns/1ps
module pcie_phy_bringup_tb_top;

  localparam int NC   = 4;
  localparam int DIV  = 4;
  localparam int HOLD = 5;
  localparam int TMO  = 6;
  localparam int SET  = 3;
  localparam int L_H  = HOLD * DIV;
  localparam int L_T  = TMO * DIV;
  localparam int L_S  = SET * DIV;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          rst_fitted_i = 1'b0;
  logic [NC-1:0] ack = '0;
  logic          test_pd_o, refclk_en_o, train_en_o, ep_rst_no, pwr_on_o;
  logic [NC-1:0] clk_en_o;
  logic          core_setup_o, ready_o, fail_o;
  logic [3:0]    dev_type_o;
  logic [5:0]    los_lvl_o, deemph_g1_o, deemph_g2_3p5_o, deemph_g2_6_o;
  logic [6:0]    swing_full_o, swing_low_o;

  pcie_phy_bringup #(
    .NUM_CLK(NC), .TICK_DIV(DIV), .RST_HOLD_US(HOLD),
    .CLK_TMO_US(TMO), .SETTLE_US(SET)
  ) dut_i (
    .clk_i, .rst_ni, .start_i, .rst_fitted_i, .clk_ack_i(ack),
    .test_pd_o, .refclk_en_o, .train_en_o, .ep_rst_no, .pwr_on_o,
    .clk_en_o, .core_setup_o, .ready_o, .fail_o,
    .dev_type_o, .los_lvl_o, .deemph_g1_o, .deemph_g2_3p5_o,
    .deemph_g2_6_o, .swing_full_o, .swing_low_o
  );

  always #2.5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Clock-generator model and event stamps
  int  dly [NC];
  bit  dead[NC];
  int  acnt[NC];
  int  t_on[NC], t_off[NC], t_ack[NC];
  int  t_pd_set, t_pd_clr, t_rst_rel, t_tr_clr, t_tr_set, t_pwr, t_ref;
  int  t_setup, setup_cnt, t_ready, t_fail;
  logic          p_pd, p_rst, p_tr, p_pwr, p_ref, p_rdy, p_fail;
  logic [NC-1:0] p_en, p_ack;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < NC; i++) begin
        acnt[i] = 0; t_on[i] = -1; t_off[i] = -1; t_ack[i] = -1;
      end
      ack = '0;
      t_pd_set = -1; t_pd_clr = -1; t_rst_rel = -1; t_tr_clr = -1; t_tr_set = -1;
      t_pwr = -1; t_ref = -1; t_setup = -1; setup_cnt = 0; t_ready = -1; t_fail = -1;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (!clk_en_o[i]) begin
          acnt[i] = 0; ack[i] = 1'b0;
        end else begin
          acnt[i]++;
          if (!dead[i] && acnt[i] >= dly[i]) ack[i] = 1'b1;
        end
        if (clk_en_o[i] && !p_en[i]) t_on[i] = cyc;
        if (!clk_en_o[i] && p_en[i]) t_off[i] = cyc;
        if (ack[i] && !p_ack[i] && t_ack[i] < 0) t_ack[i] = cyc;
      end
      if (test_pd_o && !p_pd && t_pd_set < 0) t_pd_set = cyc;
      if (!test_pd_o && p_pd) t_pd_clr = cyc;
      if (ep_rst_no && !p_rst) t_rst_rel = cyc;
      if (!train_en_o && p_tr && t_tr_clr < 0) t_tr_clr = cyc;
      if (train_en_o && !p_tr && t_tr_clr >= 0) t_tr_set = cyc;
      if (pwr_on_o && !p_pwr) t_pwr = cyc;
      if (refclk_en_o && !p_ref) t_ref = cyc;
      if (core_setup_o) begin setup_cnt++; t_setup = cyc; end
      if (ready_o && !p_rdy) t_ready = cyc;
      if (fail_o && !p_fail) t_fail = cyc;
    end
    p_pd = test_pd_o; p_rst = ep_rst_no; p_tr = train_en_o; p_pwr = pwr_on_o;
    p_ref = refclk_en_o; p_rdy = ready_o; p_fail = fail_o; p_en = clk_en_o; p_ack = ack;
  end

  task automatic run(input bit fitted, input int k, input int r, input bit slow);
    int n;
    logic [NC-1:0] en_snap;
    int cnt_snap;
    logic rdy_snap, fail_snap, pd_snap;
    for (int i = 0; i < NC; i++) begin
      dly[i]  = slow ? 20 : 1 + (r * 7 + i * 5) % 19;
      dead[i] = (i == k);
    end
    rst_fitted_i = fitted;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({test_pd_o, refclk_en_o, train_en_o, ep_rst_no, pwr_on_o, clk_en_o,
         core_setup_o, ready_o, fail_o} == '0, "R1 reset outputs",
        int'({test_pd_o, refclk_en_o, train_en_o, ep_rst_no, pwr_on_o, clk_en_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({test_pd_o, refclk_en_o, train_en_o, pwr_on_o, clk_en_o, ready_o, fail_o} == '0,
        "R1 idle outputs", int'(clk_en_o), 0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R2 reset phase on the next edge
    chk(test_pd_o && train_en_o && !refclk_en_o && !ep_rst_no, "R2 reset phase",
        int'({test_pd_o, train_en_o, refclk_en_o, ep_rst_no}), 4'b1100);
    n = 0;
    while (!(ready_o || fail_o) && n < 3000) begin
      @(negedge clk_i);
      n++;
    end
    @(negedge clk_i);
    // R3 endpoint reset hold
    if (fitted)
      chk(t_rst_rel - t_pd_set >= L_H && t_rst_rel - t_pd_set <= L_H + 3,
          "R3 reset hold", t_rst_rel - t_pd_set, L_H + 1);
    else
      chk(t_rst_rel < 0 && !ep_rst_no, "R3 no reset release", t_rst_rel, -1);
    // R4 phasing
    chk(t_tr_clr > t_pd_set && (!fitted || t_tr_clr > t_rst_rel),
        "R4 train clear after reset phase", t_tr_clr, t_pd_set + 1);
    chk(t_pwr > t_tr_clr && t_pd_clr > t_pwr && t_ref > t_pd_clr,
        "R4 pwr/pd/ref order", t_ref - t_tr_clr, 3);
    // R6 order
    chk(t_on[0] > t_ref, "R6 first clock after refclk", t_on[0], t_ref + 1);
    for (int i = 1; i <= ((k < NC) ? k : NC - 1); i++)
      chk(t_ack[i-1] >= 0 && t_on[i] > t_ack[i-1], "R6 clock after previous ack",
          t_on[i], t_ack[i-1] + 2);
    if (k < NC) begin
      // R7 timeout window and no later request
      chk(t_off[k] - t_on[k] >= L_T && t_off[k] - t_on[k] <= L_T + 3, "R7 timeout",
          t_off[k] - t_on[k], L_T + 2);
      for (int i = k + 1; i < NC; i++)
        chk(t_on[i] < 0, "R7 later clock untouched", t_on[i], -1);
      // R8 reverse unwind
      for (int i = 0; i < k; i++)
        chk(t_off[i] == t_off[i+1] + 1, "R8 reverse unwind", t_off[i], t_off[i+1] + 1);
      chk(fail_o && !ready_o && clk_en_o == '0 && t_fail == t_off[0], "R8 fail status",
          t_fail, t_off[0]);
      chk(setup_cnt == 0, "R10 no setup on failure", setup_cnt, 0);
    end else begin
      // R9 settle
      chk(t_setup - t_ack[NC-1] >= L_S && t_setup - t_ack[NC-1] <= L_S + 4, "R9 settle",
          t_setup - t_ack[NC-1], L_S + 2);
      // R10 setup pulse and training
      chk(setup_cnt == 1, "R10 single setup pulse", setup_cnt, 1);
      chk(t_tr_set > t_setup && ready_o && !fail_o && train_en_o && refclk_en_o &&
          clk_en_o == '1, "R10 ready with training", t_tr_set, t_setup + 1);
    end
    // R11 late start ignored, R12 status sticky
    en_snap = clk_en_o; cnt_snap = setup_cnt;
    rdy_snap = ready_o; fail_snap = fail_o; pd_snap = test_pd_o;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(clk_en_o == en_snap && setup_cnt == cnt_snap && test_pd_o == pd_snap,
        "R11 start ignored", int'(clk_en_o), int'(en_snap));
    chk(ready_o == rdy_snap && fail_o == fail_snap && (ready_o ^ fail_o), "R12 status held",
        int'({ready_o, fail_o}), int'({rdy_snap, fail_snap}));
  endtask

  initial begin
    // R5 static tuning fields
    #1;
    chk(dev_type_o == 4, "R5 device type", int'(dev_type_o), 4);
    chk(los_lvl_o == 9, "R5 los level", int'(los_lvl_o), 9);
    chk(deemph_g1_o == 0 && deemph_g2_3p5_o == 0, "R5 de-emphasis zero",
        int'({deemph_g1_o, deemph_g2_3p5_o}), 0);
    chk(deemph_g2_6_o == 20, "R5 6dB de-emphasis", int'(deemph_g2_6_o), 20);
    chk(swing_full_o == 127 && swing_low_o == 127, "R5 swing",
        int'(swing_full_o) + int'(swing_low_o), 254);
    for (int f = 0; f < 2; f++)
      for (int k = 0; k <= NC; k++)
        run(f[0], k, f * 5 + k, 1'b0);
    run(1'b0, NC, 11, 1'b1);
    run(1'b1, NC - 1, 12, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule